// File: doc/BRIEF.md
# Indexed Super-I/O Configuration Register File

This block holds the configuration space of a legacy super-I/O function on a byte-wide ISA-style I/O bus. The space has 256 byte registers, and two adjacent I/O ports give access to it. To reach a register, the host first writes its number to the index port. It then reads or writes that register through the data port. The current index is kept in register 0. Register 0 cannot be reached through the data port: a read there returns zero and a write there is dropped.

An enable input, driven from a bit in the host bridge's configuration space, decides whether the two ports decode at all. While the enable is low, both ports are silent: reads float to all ones and writes are lost. After reset the block holds fixed values:

- a read-only identification byte;
- a function-select byte with every function turned off;
- four base-address bytes that place the floppy, parallel and two serial windows at their usual legacy addresses.

Each base byte is decoded into a 10-bit I/O base. Each function-select bit drives an enable output. Together these produce one chip-select per function. The configuration ports take priority over the floppy window, with which they share addresses.

Top module: `sio_cfg_regs`

## Requirements
- R1: After reset the index is 0, register 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 reads 0xFE, 0xE8 reads 0xBE, and every other register reads 0x00.
- R2: A write to the index port (address 0x3F0) stores the byte as the index from the next cycle on. A read of the index port returns the stored index.
- R3: A read of the data port (address 0x3F1) returns the register selected by the index. A write to the data port updates that register, and the new value is visible from the next cycle. A data-port access leaves the index unchanged.
- R4: While the index is 0, a data-port read returns 0x00 and a data-port write changes nothing.
- R5: Register 0xE0 is read-only. Data-port writes to it leave it at 0x3C.
- R6: The ports decode, and `cfg_claim` is high for a read or write to 0x3F0 or 0x3F1, only while `cfg_en` is 1. The enable is low after the bench's reset.
- R7: Any read the block does not claim returns 0xFF. This includes every read while `cfg_en` is 0. Writes made while `cfg_en` is 0 change no register.
- R8: `fn_base` slot i (bits 10*i+9 down to 10*i) equals its base register shifted left by 2. The slots are: slot 0 floppy (0xE3), slot 1 parallel (0xE6), slot 2 serial A (0xE7), slot 3 serial B (0xE8). After reset the four bases are 0x3F0, 0x378, 0x3F8 and 0x2F8.
- R9: `fn_en` bit i equals bit i+2 of register 0xE2. Bit 2 is floppy, bit 3 parallel, bit 4 serial A and bit 5 serial B, so the reset value 0x03 enables none of them.
- R10: `fn_cs` bit i is high for a read or write whose address lies in [base_i, base_i+7] while `fn_en` bit i is 1. It is never high while that enable bit is 0.
- R11: While the block claims an access to 0x3F0 or 0x3F1, no `fn_cs` bit is high. With `cfg_en` at 0, the floppy window owns those addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Port decode enable, from the host bridge configuration bit |
| io_addr | input | 16 | I/O address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| cfg_claim | output | 1 | The access targets the index or data port and is decoded |
| fn_en | output | 4 | Per-function enables from the function-select register |
| fn_base | output | 40 | Four 10-bit decoded I/O bases, slot i at bits 10*i+9 down to 10*i |
| fn_cs | output | 4 | Per-function chip-selects for the current access |

## Verification
The assertions assume three things about the inputs: `io_rd` and `io_wr` are never high in the same cycle, the address stays steady for the whole strobe cycle, and software never gives two enabled functions overlapping windows. The last point matters because the single-owner check on `cfg_claim` and `fn_cs` depends on it. The stimulus drives one strobe at a time on the falling edge and holds the address until the next falling edge. The only base it moves in a way that could create an overlap is the floppy base. After that move, the bench reads only addresses below the serial A window.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] REG_INDEX = 8'h00;
  localparam logic [7:0] REG_DEVID = 8'hE0;
  localparam logic [7:0] REG_FNSEL = 8'hE2;
  localparam int         FN_BIT0   = 2;

  // Power-on contents of the configuration space.
  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      'hE0:    return 8'h3C;
      'hE2:    return 8'h03;
      'hE3:    return 8'hFC;
      'hE6:    return 8'hDE;
      'hE7:    return 8'hFE;
      'hE8:    return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  // Base register number for each function slot.
  function automatic logic [7:0] fn_reg_index(input int slot);
    case (slot)
      0:       return 8'hE3;
      1:       return 8'hE6;
      2:       return 8'hE7;
      3:       return 8'hE8;
      default: return 8'hE3;
    endcase
  endfunction

  function automatic logic [9:0] reg_to_base(input logic [7:0] r);
    return {r, 2'b00};
  endfunction

  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [9:0]  base,
                                     input int          span);
    logic [15:0] off;
    off = addr - {6'b0, base};
    return int'(off) < span;
  endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     PORT_BASE = 16'h03F0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              en,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd,
  output logic              claim
);
  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(PORT_BASE);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(PORT_BASE + 16'd1);

  logic at_idx, at_dat;

  assign at_idx = en && (addr == IDX_ADDR);
  assign at_dat = en && (addr == DAT_ADDR);
  assign idx_wr = at_idx && wr;
  assign idx_rd = at_idx && rd;
  assign dat_wr = at_dat && wr;
  assign dat_rd = at_dat && rd;
  assign claim  = idx_wr || idx_rd || dat_wr || dat_rd;
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_FN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idx_wr,
  input  logic                     dat_wr,
  input  logic                     idx_rd,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_FN-1:0]        fn_bits,
  output logic [NUM_FN*DATA_W-1:0] base_bytes
);
  localparam int NUM_REGS = 1 << DATA_W;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] index_q;
  logic [DATA_W-1:0] devid_q;
  logic              dat_store;
  logic              idx_zero;

  assign index_q   = regs[0];
  assign devid_q   = regs[REG_DEVID];
  assign idx_zero  = (index_q == DATA_W'(REG_INDEX));
  assign dat_store = dat_wr && !idx_zero && (index_q != DATA_W'(REG_DEVID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= DATA_W'(reset_value(i));
    end else if (idx_wr) begin
      regs[0] <= wdata;
    end else if (dat_store) begin
      regs[index_q] <= wdata;
    end
  end

  always_comb begin
    if (idx_rd)        rdata = index_q;
    else if (idx_zero) rdata = '0;
    else               rdata = regs[index_q];
  end

  assign fn_bits = regs[REG_FNSEL][FN_BIT0 +: NUM_FN];

  for (genvar g = 0; g < NUM_FN; g++) begin : g_base
    assign base_bytes[g*DATA_W +: DATA_W] = regs[fn_reg_index(g)];
  end

  // R2: index write lands in register 0
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> index_q == $past(wdata));
  // R4: data write at index 0 leaves the index alone
  a_r4_zero_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_zero) |=> idx_zero);
  // R5: identification byte never moves
  a_r5_devid_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && index_q == DATA_W'(REG_DEVID)) |=> devid_q == $past(devid_q));
endmodule

// File: rtl/sio_func_decode.sv
module sio_func_decode
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_FN   = 4,
  parameter int WIN_SPAN = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         access,
  input  logic                         cfg_claim,
  input  logic [NUM_FN-1:0]            fn_bits,
  input  logic [NUM_FN*DATA_W-1:0]     base_bytes,
  output logic [NUM_FN-1:0]            fn_en,
  output logic [NUM_FN*(DATA_W+2)-1:0] fn_base,
  output logic [NUM_FN-1:0]            fn_cs
);
  localparam int BASE_W = DATA_W + 2;

  assign fn_en = fn_bits;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    logic [BASE_W-1:0] base_g;
    logic              hit_g;

    assign base_g = reg_to_base(base_bytes[g*DATA_W +: DATA_W]);
    assign hit_g  = in_window(addr, base_g, WIN_SPAN);
    assign fn_base[g*BASE_W +: BASE_W] = base_g;
    assign fn_cs[g] = access && fn_bits[g] && hit_g && !cfg_claim;

    // R10: a disabled function never gets a select
    a_r10_cs_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      fn_cs[g] |-> fn_en[g]);
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          NUM_FN    = 4,
  parameter int          WIN_SPAN  = 8,
  parameter logic [15:0] PORT_BASE = 16'h03F0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_en,
  input  logic [ADDR_W-1:0]            io_addr,
  input  logic                         io_rd,
  input  logic                         io_wr,
  input  logic [DATA_W-1:0]            io_wdata,
  output logic [DATA_W-1:0]            io_rdata,
  output logic                         cfg_claim,
  output logic [NUM_FN-1:0]            fn_en,
  output logic [NUM_FN*(DATA_W+2)-1:0] fn_base,
  output logic [NUM_FN-1:0]            fn_cs
);
  logic                     idx_wr, idx_rd, dat_wr, dat_rd;
  logic [DATA_W-1:0]        cfg_byte;
  logic [NUM_FN-1:0]        fn_bits;
  logic [NUM_FN*DATA_W-1:0] base_bytes;
  logic                     access;

  assign access = io_rd || io_wr;

  sio_port_decode #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .en(cfg_en),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .claim(cfg_claim)
  );

  sio_cfg_regfile #(.DATA_W(DATA_W), .NUM_FN(NUM_FN)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .idx_rd(idx_rd), .wdata(io_wdata), .rdata(cfg_byte),
    .fn_bits(fn_bits), .base_bytes(base_bytes)
  );

  sio_func_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FN(NUM_FN),
                    .WIN_SPAN(WIN_SPAN)) u_fn (
    .clk(clk), .rst_n(rst_n), .addr(io_addr), .access(access),
    .cfg_claim(cfg_claim), .fn_bits(fn_bits), .base_bytes(base_bytes),
    .fn_en(fn_en), .fn_base(fn_base), .fn_cs(fn_cs)
  );

  assign io_rdata = (idx_rd || dat_rd) ? cfg_byte : '1;

  // R7: closed ports read as all ones
  a_r7_closed_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && io_rd) |-> io_rdata == '1);
  // R6: decode follows the enable input
  a_r6_claim_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_claim |-> cfg_en);
  // R11: at most one owner per access
  a_r11_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_claim, fn_cs}));
endmodule

// File: tb/sio_cfg_regs_tb.sv
module sio_cfg_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cfg_claim;
  logic [3:0]  fn_en;
  logic [39:0] fn_base;
  logic [3:0]  fn_cs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rd_val;
  logic [3:0] cs_val;
  logic       claim_val;

  always #4 clk = ~clk;

  sio_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_claim(cfg_claim), .fn_en(fn_en), .fn_base(fn_base), .fn_cs(fn_cs)
  );

  // {is_read, addr, wdata, expected, tag}
  localparam int NV = 27;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 16'h03F0, 8'hE7, 8'h00, 4'd2},
    {1'b1, 16'h03F0, 8'h00, 8'hE7, 4'd2},  // R2 index readback
    {1'b1, 16'h03F1, 8'h00, 8'hFE, 4'd3},  // R3 data read
    {1'b0, 16'h03F1, 8'h5A, 8'h00, 4'd3},
    {1'b1, 16'h03F1, 8'h00, 8'h5A, 4'd3},  // R3 data write visible
    {1'b1, 16'h03F0, 8'h00, 8'hE7, 4'd3},  // R3 index untouched
    {1'b0, 16'h03F0, 8'hE0, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'h3C, 4'd1},  // R1 device id
    {1'b0, 16'h03F1, 8'h11, 8'h00, 4'd5},
    {1'b1, 16'h03F1, 8'h00, 8'h3C, 4'd5},  // R5 read-only
    {1'b0, 16'h03F0, 8'hE2, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'h03, 4'd1},  // R1 function select
    {1'b0, 16'h03F0, 8'h40, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'h00, 4'd1},  // R1 cleared register
    {1'b0, 16'h03F1, 8'hA5, 8'h00, 4'd3},
    {1'b1, 16'h03F1, 8'h00, 8'hA5, 4'd3},
    {1'b0, 16'h03F0, 8'h00, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'h00, 4'd4},  // R4 slot 0 reads zero
    {1'b0, 16'h03F1, 8'h77, 8'h00, 4'd4},
    {1'b1, 16'h03F0, 8'h00, 8'h00, 4'd4},  // R4 write dropped
    {1'b1, 16'h03F1, 8'h00, 8'h00, 4'd4},
    {1'b0, 16'h03F0, 8'hE8, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'hBE, 4'd1},  // R1 serial B
    {1'b0, 16'h03F0, 8'hE3, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'hFC, 4'd1},  // R1 floppy
    {1'b0, 16'h03F0, 8'hE6, 8'h00, 4'd2},
    {1'b1, 16'h03F1, 8'h00, 8'hDE, 4'd1}   // R1 parallel
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b1; io_addr = a;
    #2;
    rd_val = io_rdata; cs_val = fn_cs; claim_val = cfg_claim;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [9:0] slot(input int i);
    return fn_base[i*10 +: 10];
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R9 reset enables", {12'b0, fn_en}, 16'h0000);
    check("R8 reset floppy base", {6'b0, slot(0)}, 16'h03F0);
    check("R8 reset parallel base", {6'b0, slot(1)}, 16'h0378);
    check("R8 reset serial A base", {6'b0, slot(2)}, 16'h03F8);
    check("R8 reset serial B base", {6'b0, slot(3)}, 16'h02F8);
    do_rd(16'h03F0);
    check("R6 closed after reset claim", {15'b0, claim_val}, 16'h0000);
    check("R7 closed after reset read", {8'b0, rd_val}, 16'h00FF);

    cfg_en = 1'b1;
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][36]) begin
        do_rd(VEC[k][35:20]);
        check($sformatf("R%0d vector %0d", VEC[k][3:0], k), {8'b0, rd_val}, {8'b0, VEC[k][11:4]});
      end else begin
        do_wr(VEC[k][35:20], VEC[k][19:12]);
      end
    end

    do_reset();
    cfg_en = 1'b1;
    do_wr(16'h03F0, 8'hE2);
    do_wr(16'h03F1, 8'h3C);
    check("R9 all enabled", {12'b0, fn_en}, 16'h000F);
    do_rd(16'h03FF); check("R10 serial A top", {12'b0, cs_val}, 16'h0004);
    do_rd(16'h0400); check("R10 past serial A", {12'b0, cs_val}, 16'h0000);
    do_rd(16'h02F8); check("R10 serial B", {12'b0, cs_val}, 16'h0008);
    do_rd(16'h037F); check("R10 parallel", {12'b0, cs_val}, 16'h0002);
    do_rd(16'h03F2); check("R10 floppy", {12'b0, cs_val}, 16'h0001);
    check("R7 unclaimed read", {8'b0, rd_val}, 16'h00FF);
    do_rd(16'h03F1);
    check("R11 cfg owns port cs", {12'b0, cs_val}, 16'h0000);
    check("R6 claim when enabled", {15'b0, claim_val}, 16'h0001);
    check("R3 read E2", {8'b0, rd_val}, 16'h003C);

    @(negedge clk); cfg_en = 1'b0;
    do_rd(16'h03F0);
    check("R11 floppy owns port", {12'b0, cs_val}, 16'h0001);
    check("R7 disabled read", {8'b0, rd_val}, 16'h00FF);
    check("R6 no claim disabled", {15'b0, claim_val}, 16'h0000);
    do_wr(16'h03F0, 8'hE3);
    do_wr(16'h03F1, 8'h00);
    @(negedge clk); cfg_en = 1'b1;
    do_rd(16'h03F0);
    check("R7 index kept", {8'b0, rd_val}, 16'h00E2);
    check("R7 floppy base kept", {6'b0, slot(0)}, 16'h03F0);

    do_wr(16'h03F1, 8'h14);
    check("R9 partial enables", {12'b0, fn_en}, 16'h0005);
    do_rd(16'h02F8); check("R10 disabled serial B", {12'b0, cs_val}, 16'h0000);
    do_rd(16'h03FA); check("R10 serial A still", {12'b0, cs_val}, 16'h0004);

    do_wr(16'h03F0, 8'hE8);
    do_wr(16'h03F1, 8'h40);
    check("R8 serial B moved", {6'b0, slot(3)}, 16'h0100);
    do_wr(16'h03F0, 8'hE3);
    do_wr(16'h03F1, 8'hFD);
    check("R8 floppy odd base", {6'b0, slot(0)}, 16'h03F4);
    do_rd(16'h03F3); check("R10 below floppy", {12'b0, cs_val}, 16'h0000);
    do_rd(16'h03F4); check("R10 floppy start", {12'b0, cs_val}, 16'h0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule